// File: doc/BRIEF.md
# Atomic Bit Set/Clear Output Register

This block keeps a 16-bit output value that software can change in two ways. Through the data register the whole value, or any byte of it, can be read and written like an ordinary register. Through the set/clear word, one bus write can force chosen bits high and other chosen bits low. No read-modify-write sequence is needed, so an interrupt arriving between a read and a write cannot corrupt a bit that another context owns.

Bits 15:0 of the set/clear word are set controls and bits 31:16 are clear controls. A 1 in a control acts on its output bit, and a 0 leaves that bit alone. When one write asks to both set and clear the same bit, the set wins. The word acts once per write and holds nothing: it always reads as zero. Byte strobes decide which controls count, so a byte write to the upper half clears bits and sets none. The output value is driven straight from the register, and the block has no status, no handshake and no pad control.

Top module: `gpo_atomic_out`

## Requirements
- R1: While reset is asserted and after it is released, the output value is 0x0000 and the data register reads 0x00000000.
- R2: A write to the data register (byte offset 0x0) loads byte k of the output from write-data byte k for each strobed byte k in {0,1}. Unstrobed bytes keep their value, and strobes 2 and 3 have no effect.
- R3: A write to the set/clear word (byte offset 0x4) with write-data bit i = 1 (i in 0..15, lane strobed) makes output bit i equal to 1.
- R4: A write to the set/clear word with write-data bit i+16 = 1 (lane strobed) and bit i = 0 makes output bit i equal to 0.
- R5: Set/clear controls written as 0 leave their output bits unchanged.
- R6: When a set/clear write carries 1 in both bit i and bit i+16, output bit i becomes 1.
- R7: The set/clear word always reads as 0x00000000.
- R8: The data register reads with bits 31:16 at zero and bits 15:0 equal to the current output value.
- R9: Strobe k gates set/clear write-data bits 8k+7..8k. A write strobing only lanes 2 and/or 3 clears bits and sets none.
- R10: The output changes on the clock edge that completes a write and holds its value in every cycle without a write.
- R11: Writes to the unmapped offsets 0x8 and 0xC leave the output unchanged, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes, one per byte lane of write data |
| bus_wen | input | 1 | Write enable, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| out_val | output | 16 | Current output value |

## Verification
The hardest case to reach is a single set/clear write where set, clear, collision and untouched bits appear together under a partial strobe pattern. In that case the result depends on how the lane gating and the set priority combine. The bench reaches it by preloading a known background value through the data register. It then sweeps all sixteen strobe patterns over set/clear words whose halves overlap in part, and compares each result with an arithmetic model. Walking one set bit and one clear bit across all sixteen positions, and checking the output just before and just after the write edge, covers the single-bit and timing corners.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_SETCLR = 2'd2
  } gpo_sel_e;
endpackage

// File: rtl/gpo_addr_dec.sv
module gpo_addr_dec
  import gpo_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h0,
  parameter logic [ADDR_W-1:0] SC_OFS   = 'h4
) (
  input  logic [ADDR_W-1:0] addr,
  output gpo_sel_e          sel
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] DATA_IDX = DATA_OFS[ADDR_W-1:2];
  localparam logic [IDX_W-1:0] SC_IDX   = SC_OFS[ADDR_W-1:2];

  logic [IDX_W-1:0] word_idx;

  always_comb begin
    word_idx = addr[ADDR_W-1:2];
    if (word_idx == DATA_IDX)      sel = SEL_DATA;
    else if (word_idx == SC_IDX)   sel = SEL_SETCLR;
    else                           sel = SEL_NONE;
  end
endmodule

// File: rtl/gpo_lane_mask.sv
module gpo_lane_mask #(
  parameter int BUS_W = 32
) (
  input  logic [BUS_W/8-1:0] strb,
  output logic [BUS_W-1:0]   mask
);
  localparam int LANES = BUS_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mask[8*k +: 8] = {8{strb[k]}};
  end
endmodule

// File: rtl/gpo_next.sv
module gpo_next
  import gpo_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  gpo_sel_e             sel,
  input  logic                 wen,
  input  logic [BUS_W/2-1:0]   cur,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [BUS_W-1:0]     bmask,
  output logic [BUS_W/2-1:0]   nxt,
  output logic                 upd
);
  localparam int DATA_W = BUS_W / 2;

  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] low_mask;

  always_comb begin
    low_mask = bmask[DATA_W-1:0];
    set_bits = wdata[DATA_W-1:0] & bmask[DATA_W-1:0];
    clr_bits = wdata[BUS_W-1:DATA_W] & bmask[BUS_W-1:DATA_W];
    nxt      = cur;
    upd      = 1'b0;
    if (wen) begin
      unique case (sel)
        SEL_DATA: begin
          nxt = (cur & ~low_mask) | (wdata[DATA_W-1:0] & low_mask);
          upd = 1'b1;
        end
        SEL_SETCLR: begin
          // clear first, then set, so a set control overrides its clear
          nxt = (cur & ~clr_bits) | set_bits;
          upd = 1'b1;
        end
        default: begin
          nxt = cur;
          upd = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/gpo_atomic_out.sv
module gpo_atomic_out
  import gpo_pkg::*;
#(
  parameter int                BUS_W    = 32,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h0,
  parameter logic [ADDR_W-1:0] SC_OFS   = 'h4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic [BUS_W/8-1:0]   bus_wstrb,
  input  logic                 bus_wen,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [BUS_W/2-1:0]   out_val
);
  localparam int DATA_W = BUS_W / 2;

  gpo_sel_e          sel;
  logic [BUS_W-1:0]  bmask;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] out_d;
  logic              out_en;

  gpo_addr_dec #(
    .ADDR_W  (ADDR_W),
    .DATA_OFS(DATA_OFS),
    .SC_OFS  (SC_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  gpo_lane_mask #(.BUS_W(BUS_W)) u_mask (
    .strb(bus_wstrb),
    .mask(bmask)
  );

  gpo_next #(.BUS_W(BUS_W)) u_next (
    .sel  (sel),
    .wen  (bus_wen),
    .cur  (out_q),
    .wdata(bus_wdata),
    .bmask(bmask),
    .nxt  (out_d),
    .upd  (out_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel == SEL_DATA) bus_rdata[DATA_W-1:0] = out_q;
  end

  assign out_val = out_q;
endmodule

// File: rtl/gpo_atomic_out_chk.sv
module gpo_atomic_out_chk #(
  parameter int                BUS_W    = 32,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h0,
  parameter logic [ADDR_W-1:0] SC_OFS   = 'h4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [BUS_W/8-1:0]   bus_wstrb,
  input logic                 bus_wen,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic [BUS_W/2-1:0]   out_val
);
  localparam int DW = BUS_W / 2;

  logic [BUS_W-1:0] lanes;
  for (genvar k = 0; k < BUS_W/8; k++) begin : g_l
    assign lanes[8*k +: 8] = {8{bus_wstrb[k]}};
  end

  logic          hit_sc, hit_data;
  logic [DW-1:0] set_m, clr_m, clr_only;
  assign hit_sc   = bus_addr[ADDR_W-1:2] == SC_OFS[ADDR_W-1:2];
  assign hit_data = bus_addr[ADDR_W-1:2] == DATA_OFS[ADDR_W-1:2];
  assign set_m    = bus_wdata[DW-1:0] & lanes[DW-1:0];
  assign clr_m    = bus_wdata[BUS_W-1:DW] & lanes[BUS_W-1:DW];
  assign clr_only = clr_m & ~set_m;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> out_val == '0);

  p_set_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && hit_sc) |=> ((out_val & $past(set_m)) == $past(set_m)));

  p_clear_applies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && hit_sc) |=> ((out_val & $past(clr_only)) == '0));

  p_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && hit_sc) |=> (((out_val ^ $past(out_val)) & ~$past(set_m | clr_m)) == '0));

  p_sc_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sc |-> bus_rdata == '0);

  p_data_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data |-> (bus_rdata[BUS_W-1:DW] == '0 && bus_rdata[DW-1:0] == out_val));

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> $stable(out_val));

  p_unmapped_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && !hit_sc && !hit_data) |=> $stable(out_val));
endmodule

bind gpo_atomic_out gpo_atomic_out_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .SC_OFS(SC_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wstrb(bus_wstrb), .bus_wen(bus_wen), .bus_rdata(bus_rdata),
  .out_val(out_val)
);

// File: tb/sim_gpo_atomic_out.sv
module sim_gpo_atomic_out;
  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic        bus_wen;
  logic [31:0] bus_rdata;
  logic [15:0] out_val;

  int   n_chk;
  int   n_fail;
  int   cyc;
  logic done;
  logic [15:0] model;

  gpo_atomic_out u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb), .bus_wen(bus_wen), .bus_rdata(bus_rdata),
    .out_val(out_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] s);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{s[k]}};
    return m;
  endfunction

  function automatic logic [15:0] m_data(input logic [15:0] c, input logic [31:0] w, input logic [3:0] s);
    logic [31:0] m;
    m = lanes(s);
    return (c & ~m[15:0]) | (w[15:0] & m[15:0]);
  endfunction

  function automatic logic [15:0] m_sc(input logic [15:0] c, input logic [31:0] w, input logic [3:0] s);
    logic [31:0] m;
    logic [31:0] e;
    m = lanes(s);
    e = w & m;
    return (c & ~e[31:16]) | e[15:0];
  endfunction

  // drive at negedge, write lands at the next posedge, sampled at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_addr  = a;
    bus_wdata = d;
    bus_wstrb = s;
    bus_wen   = 1'b1;
    @(negedge clk);
    bus_wen   = 1'b0;
    if (a == 4'h0)      model = m_data(model, d, s);
    else if (a == 4'h4) model = m_sc(model, d, s);
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0; model = '0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wstrb = '0; bus_wen = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out in reset", {16'h0, out_val}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", {16'h0, out_val}, 32'h0);
    rd_check("R1 data read", 4'h0, 32'h0);

    // R2: every strobe combination on direct writes
    for (int s = 0; s < 16; s++) begin
      wr(4'h0, 32'h5A5A_0000 | (32'h1234 * (s + 1)), s[3:0]);
      check("R2 direct write", {16'h0, out_val}, {16'h0, model});
    end

    // R3 / R4: walk each bit
    for (int i = 0; i < 16; i++) begin
      wr(4'h0, 32'h0, 4'hF);
      wr(4'h4, 32'h1 << i, 4'hF);
      check("R3 set bit", {16'h0, out_val}, {16'h0, 16'h1 << i});
      wr(4'h0, 32'hFFFF, 4'hF);
      wr(4'h4, 32'h1 << (i + 16), 4'hF);
      check("R4 clear bit", {16'h0, out_val}, {16'h0, ~(16'h1 << i)});
    end

    // R5: all-zero control word
    wr(4'h0, 32'hC3A5, 4'h3);
    wr(4'h4, 32'h0, 4'hF);
    check("R5 zero controls", {16'h0, out_val}, 32'h0000_C3A5);

    // R6: collisions
    wr(4'h0, 32'h0, 4'h3);
    wr(4'h4, 32'hFFFF_FFFF, 4'hF);
    check("R6 set wins all", {16'h0, out_val}, 32'h0000_FFFF);
    wr(4'h4, 32'hFF0F_00F0, 4'hF);
    check("R6 partial overlap", {16'h0, out_val}, {16'h0, model});

    // R9: every strobe combination on set/clear over several backgrounds
    for (int b = 0; b < 3; b++) begin
      for (int s = 0; s < 16; s++) begin
        wr(4'h0, (b == 0) ? 32'h0 : (b == 1) ? 32'hFFFF : 32'h9C63, 4'h3);
        wr(4'h4, 32'h3CF0_0FF3, s[3:0]);
        check("R9 strobe gated setclr", {16'h0, out_val}, {16'h0, model});
      end
    end
    wr(4'h0, 32'hFFFF, 4'h3);
    wr(4'h4, 32'h00F0_FFFF, 4'h4);
    check("R9 upper-lane clear only", {16'h0, out_val}, 32'h0000_FF0F);

    // R7 / R8 reads
    rd_check("R7 setclr reads zero", 4'h4, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF, 4'hF);
    rd_check("R8 upper half zero", 4'h0, 32'h0000_FFFF);

    // R10: timing of the update and idle stability
    bus_addr = 4'h0; bus_wdata = 32'h1357; bus_wstrb = 4'h3; bus_wen = 1'b1;
    #1;
    check("R10 before edge", {16'h0, out_val}, 32'h0000_FFFF);
    @(negedge clk);
    bus_wen = 1'b0; model = 16'h1357;
    check("R10 after edge", {16'h0, out_val}, 32'h0000_1357);
    repeat (4) @(negedge clk);
    check("R10 idle hold", {16'h0, out_val}, 32'h0000_1357);

    // R11: unmapped offsets
    wr(4'h8, 32'hFFFF_FFFF, 4'hF);
    check("R11 write 0x8 ignored", {16'h0, out_val}, 32'h0000_1357);
    wr(4'hC, 32'h0000_0000, 4'hF);
    check("R11 write 0xC ignored", {16'h0, out_val}, 32'h0000_1357);
    rd_check("R11 read 0x8", 4'h8, 32'h0);
    rd_check("R11 read 0xC", 4'hC, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule